// File: doc/BRIEF.md
# Frame Error Status and Interrupt Aggregator

This block gathers six fault conditions reported by a CAN protocol engine into sticky status flags. There is one flag for each of bus error, arbitration lost, error warning, error passive, bus off and receive pre-buffer overflow. A one-cycle pulse on a condition's event input latches its flag. The flag stays set until it is cleared. Each condition also has an enable bit. When an event arrives for an enabled condition, the block raises a single summary frame-error interrupt flag.

Software writes the enable register and clears the summary flag through a small register-style write port, and it reads the flags on a status port. Per-flag clear strobes clear every condition except bus error. The bus-error flag is cleared only by a strobe that marks a read of the external error code capture register.

Clearing the interrupt takes two steps. First every status flag is cleared. After that, a write of 1 to the summary bit clears the interrupt. A summary clear issued while any flag is still set is dropped.

Top module: `fe_frame_err_agg`

## Requirements
- R1: While `rst` is high at a clock edge, all status flags, all enable bits and `irq_o` go to 0 at that edge.
- R2: A pulse on `evt_i[k]` sets status bit k on the next edge. The bit then stays set until it is cleared. The bit map is: 0 arbitration lost, 1 error warning, 2 error passive, 3 bus error, 4 bus off, 5 pre-buffer overflow.
- R3: `status_o[7:6]` always read 0.
- R4: `flag_clr_i[k]` clears status bit k for k in {0,1,2,4,5}. `flag_clr_i[3]` has no effect.
- R5: `capture_rd_i` clears status bit 3, the bus-error flag, and no other bit.
- R6: When a set event and a clear arrive for the same flag in the same cycle, the flag ends up set.
- R7: `irq_o` is set on the edge after an event whose enable bit is 1. An event whose enable bit is 0 sets its status flag but does not touch `irq_o`.
- R8: A summary clear is a write with `wr_sel_i`=1 and `wr_data_i[0]`=1. It clears `irq_o` only if status bits 5:0 are all 0 in that cycle. Otherwise it is ignored. A write with `wr_data_i[0]`=0 has no effect.
- R9: A write with `wr_sel_i`=0 loads `wr_data_i[5:0]` into the enable register, which reads back on `enable_o`. Upper data bits are ignored.
- R10: If an enabled event and an accepted summary clear occur in the same cycle, `irq_o` stays set.
- R11: Enabling a condition whose flag is already set does not raise `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 6 | Condition event pulses, one per status bit |
| flag_clr_i | input | 6 | Per-flag clear strobes (bit 3 unused) |
| capture_rd_i | input | 1 | Error capture register read strobe; clears bus-error flag |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 enable register, 1 summary clear |
| wr_data_i | input | 8 | Write data |
| status_o | output | 8 | Status flags; bits 7:6 reserved as 0 |
| enable_o | output | 6 | Enable register readback |
| irq_o | output | 1 | Summary frame-error interrupt flag |

## Verification
The bench issues a summary clear while flags are still pending. A design that skipped the all-clear gate would drop `irq_o` early and lose the interrupt. It drives a per-flag clear at bit 3 and a capture read alongside other flags. A design that mixed up the bus-error clear path would clear the wrong bit or fail to clear the right one. It pairs a set with a clear in the same cycle, on one flag and on the summary flag. If clear took priority there, an event would vanish without a trace. It also enables a condition whose flag is already latched, to catch a design that derives `irq_o` from the level of the flags rather than from the events.

// File: rtl/fe_agg_pkg.sv
package fe_agg_pkg;

    localparam int NUM_COND = 6;
    localparam int STATUS_W = 8;
    localparam int DATA_W   = 8;

    typedef enum logic [2:0] {
        COND_ARB_LOST    = 3'd0,
        COND_ERR_WARN    = 3'd1,
        COND_ERR_PASSIVE = 3'd2,
        COND_BUS_ERR     = 3'd3,
        COND_BUS_OFF     = 3'd4,
        COND_PREBUF_OVF  = 3'd5
    } cond_e;

    typedef enum logic {
        WSEL_ENABLE  = 1'b0,
        WSEL_SUMMARY = 1'b1
    } wsel_e;

    localparam int SUMMARY_CLR_BIT = 0;

    typedef struct packed {
        logic [NUM_COND-1:0] set;
        logic [NUM_COND-1:0] clr;
    } flag_ctl_t;

    typedef struct packed {
        logic                enable_wr;
        logic                summary_clr;
        logic [NUM_COND-1:0] enable_val;
    } reg_wr_t;

    // Bus-error flag follows the capture read strobe; all others follow their own clear.
    function automatic logic [NUM_COND-1:0] build_clear_mask(
        input logic [NUM_COND-1:0] per_flag_clr,
        input logic                capture_rd
    );
        logic [NUM_COND-1:0] m;
        for (int k = 0; k < NUM_COND; k++) begin
            if (k == int'(COND_BUS_ERR)) m[k] = capture_rd;
            else                         m[k] = per_flag_clr[k];
        end
        return m;
    endfunction

endpackage

// File: rtl/fe_cond_router.sv
module fe_cond_router
    import fe_agg_pkg::*;
#(
    parameter int N = NUM_COND,
    parameter int W = DATA_W
) (
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] flag_clr_i,
    input  logic         capture_rd_i,
    input  logic         wr_en_i,
    input  logic         wr_sel_i,
    input  logic [W-1:0] wr_data_i,
    output flag_ctl_t    ctl_o,
    output reg_wr_t      wr_o
);
    always_comb begin
        ctl_o.set = evt_i;
        ctl_o.clr = build_clear_mask(flag_clr_i, capture_rd_i);
    end

    always_comb begin
        wr_o.enable_wr   = wr_en_i && (wsel_e'(wr_sel_i) == WSEL_ENABLE);
        wr_o.summary_clr = wr_en_i && (wsel_e'(wr_sel_i) == WSEL_SUMMARY)
                           && wr_data_i[SUMMARY_CLR_BIT];
        wr_o.enable_val  = wr_data_i[N-1:0];
    end
endmodule

// File: rtl/fe_flag_bank.sv
module fe_flag_bank
    import fe_agg_pkg::*;
#(
    parameter int N = NUM_COND
) (
    input  logic         clk,
    input  logic         rst,
    input  flag_ctl_t    ctl_i,
    output logic [N-1:0] flags_o
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                flags_o[g] <= 1'b0;
            else if (ctl_i.set[g])  flags_o[g] <= 1'b1;
            else if (ctl_i.clr[g])  flags_o[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/fe_enable_reg.sv
module fe_enable_reg
    import fe_agg_pkg::*;
#(
    parameter int N = NUM_COND
) (
    input  logic         clk,
    input  logic         rst,
    input  reg_wr_t      wr_i,
    output logic [N-1:0] enable_o
);
    always_ff @(posedge clk) begin
        if (rst)                 enable_o <= '0;
        else if (wr_i.enable_wr) enable_o <= wr_i.enable_val;
    end
endmodule

// File: rtl/fe_summary.sv
module fe_summary
    import fe_agg_pkg::*;
#(
    parameter int N = NUM_COND
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] enable_i,
    input  logic [N-1:0] flags_i,
    input  logic         clr_req_i,
    output logic         irq_o
);
    logic set_req;
    logic clr_ok;

    assign set_req = |(evt_i & enable_i);
    assign clr_ok  = clr_req_i && (flags_i == '0);

    always_ff @(posedge clk) begin
        if (rst)          irq_o <= 1'b0;
        else if (set_req) irq_o <= 1'b1;
        else if (clr_ok)  irq_o <= 1'b0;
    end
endmodule

// File: rtl/fe_frame_err_agg.sv
module fe_frame_err_agg
    import fe_agg_pkg::*;
#(
    parameter int N  = NUM_COND,
    parameter int SW = STATUS_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  evt_i,
    input  logic [N-1:0]  flag_clr_i,
    input  logic          capture_rd_i,
    input  logic          wr_en_i,
    input  logic          wr_sel_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [SW-1:0] status_o,
    output logic [N-1:0]  enable_o,
    output logic          irq_o
);
    localparam int RSV_W = SW - N;

    flag_ctl_t    ctl;
    reg_wr_t      wr;
    logic [N-1:0] flags;

    fe_cond_router #(.N(N), .W(DW)) u_router (
        .evt_i        (evt_i),
        .flag_clr_i   (flag_clr_i),
        .capture_rd_i (capture_rd_i),
        .wr_en_i      (wr_en_i),
        .wr_sel_i     (wr_sel_i),
        .wr_data_i    (wr_data_i),
        .ctl_o        (ctl),
        .wr_o         (wr)
    );

    fe_flag_bank #(.N(N)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .ctl_i   (ctl),
        .flags_o (flags)
    );

    fe_enable_reg #(.N(N)) u_enable (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr),
        .enable_o (enable_o)
    );

    fe_summary #(.N(N)) u_summary (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (evt_i),
        .enable_i  (enable_o),
        .flags_i   (flags),
        .clr_req_i (wr.summary_clr),
        .irq_o     (irq_o)
    );

    if (RSV_W > 0) begin : g_rsv
        assign status_o = {{RSV_W{1'b0}}, flags};
    end else begin : g_norsv
        assign status_o = flags;
    end
endmodule

// File: rtl/fe_agg_chk.sv
module fe_agg_chk
    import fe_agg_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [NUM_COND-1:0] evt_i,
    input logic                capture_rd_i,
    input logic                wr_en_i,
    input logic                wr_sel_i,
    input logic [DATA_W-1:0]   wr_data_i,
    input logic [STATUS_W-1:0] status_o,
    input logic [NUM_COND-1:0] enable_o,
    input logic                irq_o
);
    logic sum_wr;
    assign sum_wr = wr_en_i && wr_sel_i && wr_data_i[0];

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (status_o == '0 && enable_o == '0 && !irq_o));

    assert_event_latch_R2: assert property (@(posedge clk) disable iff (rst)
        (|evt_i) |=> ((status_o[NUM_COND-1:0] & $past(evt_i)) == $past(evt_i)));

    assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (rst)
        status_o[STATUS_W-1:NUM_COND] == '0);

    assert_buserr_clear_src_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(status_o[3]) && !$past(rst)) |-> $past(capture_rd_i));

    assert_enabled_sets_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (|(evt_i & enable_o)) |=> irq_o);

    assert_irq_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq_o) && !$past(rst)) |-> $past(|(evt_i & enable_o)));

    assert_irq_clear_gate_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(irq_o) && !$past(rst)) |->
            ($past(sum_wr) && $past(status_o[NUM_COND-1:0]) == '0));
endmodule

bind fe_frame_err_agg fe_agg_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .evt_i        (evt_i),
    .capture_rd_i (capture_rd_i),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_data_i    (wr_data_i),
    .status_o     (status_o),
    .enable_o     (enable_o),
    .irq_o        (irq_o)
);

// File: tb/fe_frame_err_agg_tb.sv
module fe_frame_err_agg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 20;

    typedef struct packed {
        logic [5:0] evt;
        logic [5:0] clr;
        logic       cap;
        logic       we;
        logic       sel;
        logic [7:0] wd;
        logic [7:0] ex_st;
        logic       ex_irq;
        logic [5:0] ex_en;
    } vec_t;

    // evt, clr, cap, we, sel, wd, expected status, expected irq, expected enable
    localparam logic [37:0] VECS [NV] = '{
        {6'h00,6'h00,1'b0,1'b1,1'b0,8'h09, 8'h00,1'b0,6'h09}, // R9 enable load
        {6'h02,6'h00,1'b0,1'b0,1'b0,8'h00, 8'h02,1'b0,6'h09}, // R7 disabled event
        {6'h01,6'h00,1'b0,1'b0,1'b0,8'h00, 8'h03,1'b1,6'h09}, // R2 R7 enabled event
        {6'h00,6'h00,1'b0,1'b1,1'b1,8'h01, 8'h03,1'b1,6'h09}, // R8 clear ignored
        {6'h00,6'h03,1'b0,1'b0,1'b0,8'h00, 8'h00,1'b1,6'h09}, // R4 flag clears
        {6'h00,6'h00,1'b0,1'b1,1'b1,8'h01, 8'h00,1'b0,6'h09}, // R8 clear accepted
        {6'h08,6'h00,1'b0,1'b0,1'b0,8'h00, 8'h08,1'b1,6'h09}, // R2 bus error
        {6'h00,6'h08,1'b0,1'b0,1'b0,8'h00, 8'h08,1'b1,6'h09}, // R4 bit3 clear ignored
        {6'h00,6'h00,1'b1,1'b0,1'b0,8'h00, 8'h00,1'b1,6'h09}, // R5 capture read
        {6'h10,6'h10,1'b0,1'b0,1'b0,8'h00, 8'h10,1'b1,6'h09}, // R6 set wins
        {6'h00,6'h10,1'b0,1'b0,1'b0,8'h00, 8'h00,1'b1,6'h09}, // R4
        {6'h01,6'h00,1'b0,1'b1,1'b1,8'h01, 8'h01,1'b1,6'h09}, // R10 set beats clear
        {6'h20,6'h01,1'b0,1'b0,1'b0,8'h00, 8'h20,1'b1,6'h09}, // R2 R4
        {6'h00,6'h20,1'b0,1'b0,1'b0,8'h00, 8'h00,1'b1,6'h09}, // R4
        {6'h00,6'h00,1'b0,1'b1,1'b1,8'h01, 8'h00,1'b0,6'h09}, // R8
        {6'h00,6'h00,1'b0,1'b1,1'b0,8'hFF, 8'h00,1'b0,6'h3F}, // R9 upper bits dropped
        {6'h3F,6'h00,1'b0,1'b0,1'b0,8'h00, 8'h3F,1'b1,6'h3F}, // R2 R3 all flags
        {6'h00,6'h37,1'b1,1'b0,1'b0,8'h00, 8'h00,1'b1,6'h3F}, // R4 R5 combined
        {6'h00,6'h00,1'b0,1'b1,1'b1,8'h00, 8'h00,1'b1,6'h3F}, // R8 data bit0 zero
        {6'h00,6'h00,1'b0,1'b1,1'b1,8'h01, 8'h00,1'b0,6'h3F}  // R8
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] evt_i, flag_clr_i;
    logic       capture_rd_i, wr_en_i, wr_sel_i;
    logic [7:0] wr_data_i;
    logic [7:0] status_o;
    logic [5:0] enable_o;
    logic       irq_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fe_frame_err_agg dut_i (
        .clk(clk), .rst(rst), .evt_i(evt_i), .flag_clr_i(flag_clr_i),
        .capture_rd_i(capture_rd_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
        .wr_data_i(wr_data_i), .status_o(status_o), .enable_o(enable_o),
        .irq_o(irq_o)
    );

    task automatic check(input string req, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        evt_i = '0; flag_clr_i = '0; capture_rd_i = 1'b0;
        wr_en_i = 1'b0; wr_sel_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic step(input vec_t v);
        @(negedge clk);
        evt_i = v.evt; flag_clr_i = v.clr; capture_rd_i = v.cap;
        wr_en_i = v.we; wr_sel_i = v.sel; wr_data_i = v.wd;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        vec_t v;
        idle_inputs();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "status", status_o, 8'h00);
        check("R1", "irq", {7'b0, irq_o}, 8'h00);
        check("R1", "enable", {2'b0, enable_o}, 8'h00);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NV; k++) begin
            v = vec_t'(VECS[k]);
            step(v);
            check($sformatf("vec%0d", k), "status", status_o, v.ex_st);
            check($sformatf("vec%0d", k), "irq", {7'b0, irq_o}, {7'b0, v.ex_irq});
            check($sformatf("vec%0d", k), "enable", {2'b0, enable_o}, {2'b0, v.ex_en});
        end

        // R11: latch a flag while disabled, then enable it: no interrupt
        step(vec_t'({6'h00,6'h00,1'b0,1'b1,1'b0,8'h00, 8'h00,1'b0,6'h00}));
        step(vec_t'({6'h04,6'h00,1'b0,1'b0,1'b0,8'h00, 8'h04,1'b0,6'h00}));
        check("R11", "status", status_o, 8'h04);
        step(vec_t'({6'h00,6'h00,1'b0,1'b1,1'b0,8'h04, 8'h04,1'b0,6'h04}));
        check("R11", "enable", {2'b0, enable_o}, 8'h04);
        @(posedge clk); #1;
        check("R11", "irq after enable", {7'b0, irq_o}, 8'h00);

        // R3 with reserved bits idle while flags held
        check("R3", "reserved bits", {6'b0, status_o[7:6]}, 8'h00);

        // R1: reset in mid-run with flags and irq set
        step(vec_t'({6'h3C,6'h00,1'b0,1'b0,1'b0,8'h00, 8'h00,1'b0,6'h00}));
        check("R7", "irq before reset", {7'b0, irq_o}, 8'h01);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        check("R1", "status after reset", status_o, 8'h00);
        check("R1", "irq after reset", {7'b0, irq_o}, 8'h00);
        check("R1", "enable after reset", {2'b0, enable_o}, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule